// File: doc/BRIEF.md
# Soft-Decision Depuncturer for a Rate-1/2 Convolutional Decoder

This block takes punctured soft-decision symbols from a demodulator and rebuilds the full stream of mother-code symbol pairs that a rate-1/2, constraint-length-7 trellis decoder expects. Each input strobe delivers one 3-bit I sample and one 3-bit Q sample. On the transmit side the surviving code terms were taken in order (first X, then Y, then the next column) and dealt alternately onto I and Q. The block reverses that mapping. It writes every arriving symbol into a small reorder buffer. It then walks the puncture pattern of the selected code rate one column per clock and emits an X/Y pair as soon as the symbols kept in that column are present. A deleted term comes out as a zero value with its erasure flag set, so the decoder's branch metric can ignore it.

A phase input chooses the column where the pattern walk begins. An external synchroniser that has lost lock can step through every alignment in turn. When either the rate or the phase changes, the block discards everything it holds and restarts from the selected column. A pulse on the output marks each pair built from the first column of the pattern, which gives downstream logic a period boundary.

Top module: `depuncturer`

## Requirements
- R1: `rate_code` selects 0 = 1/2, 1 = 2/3, 2 = 3/4, 3 = 5/6, 4 = 6/7, 5 = 7/8; codes 6 and 7 behave exactly as rate 1/2.
- R2: Kept terms per column (column 0 first, X then Y) are: 1/2 X=1 Y=1; 2/3 X=10 Y=11; 3/4 X=101 Y=110; 5/6 X=10101 Y=11010; 6/7 X=100101 Y=111010; 7/8 X=1000101 Y=1111010. The pattern period in columns is the length of these strings.
- R3: Each strobe appends I and then Q to the symbol stream. Each pair takes its kept terms from the front of that stream, X before Y, so the symbols reappear in arrival order.
- R4: A deleted term is output as value 3'b000 with its erasure flag high; a kept term has its flag low. No pair has both terms deleted.
- R5: After a flush or reset the first pair uses column `phase` mod period, and the columns then advance by one per pair and wrap to 0.
- R6: `period_start` is high exactly on output pairs built from column 0, and never without `out_valid`.
- R7: A change of `rate_code` or `phase` discards all buffered symbols and any strobe in that same cycle, and restarts the pattern at the column given by R5.
- R8: Reset (synchronous, active high) clears `out_valid`, `period_start` and the buffer, and sets the pattern to the column given by R5.
- R9: At most one pair is emitted per clock. A pair is emitted only once all of its kept terms have arrived. Symbols that do not fill a column stay held.
- R10: The buffer holds `DEPTH` symbols (default 8). With strobes no more often than every other clock it never fills, at any rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_code | input | 3 | Code rate select (R1) |
| phase | input | 3 | Starting pattern column, reduced modulo the period |
| in_valid | input | 1 | Strobe: in_i and in_q are valid |
| in_i | input | SOFT_W | Soft I sample |
| in_q | input | SOFT_W | Soft Q sample |
| out_valid | output | 1 | An X/Y pair is present |
| out_x | output | SOFT_W | Soft X term (zero if erased) |
| out_y | output | SOFT_W | Soft Y term (zero if erased) |
| out_x_era | output | 1 | X term is an erasure |
| out_y_era | output | 1 | Y term is an erasure |
| period_start | output | 1 | Pair built from pattern column 0 |

## Verification
A wrong column counter shows at once in the erasure flags and in `period_start`, because those follow the pattern and not the data. One column too far makes the very next pair carry the wrong flags. A buffer that keeps or drops a symbol across a flush or reset shifts every later pair by one term. That shows as a value mismatch in the first pair after the change. Holding too few symbols shows as a missing pair at the end of a burst whose length is a whole number of periods.

// File: rtl/depunct_pkg.sv
package depunct_pkg;

    localparam int MAX_COLS = 7;

    typedef logic [2:0] col_t;
    typedef logic [MAX_COLS-1:0] mask_t;

    typedef enum logic [2:0] {
        RATE_1_2 = 3'd0,
        RATE_2_3 = 3'd1,
        RATE_3_4 = 3'd2,
        RATE_5_6 = 3'd3,
        RATE_6_7 = 3'd4,
        RATE_7_8 = 3'd5
    } rate_e;

    // Active pattern description handed from the config stage to the selector
    typedef struct packed {
        col_t  start;
        col_t  len;
        mask_t xm;
        mask_t ym;
    } pat_cfg_t;

    function automatic rate_e decode_rate(input logic [2:0] code);
        if (code > 3'd5) return RATE_1_2;
        return rate_e'(code);
    endfunction

    // Bit c set = X term of column c is transmitted
    function automatic mask_t x_mask(input rate_e r);
        case (r)
            RATE_2_3: return 7'b0000001;
            RATE_3_4: return 7'b0000101;
            RATE_5_6: return 7'b0010101;
            RATE_6_7: return 7'b0101001;
            RATE_7_8: return 7'b1010001;
            default:  return 7'b0000001;
        endcase
    endfunction

    // Bit c set = Y term of column c is transmitted
    function automatic mask_t y_mask(input rate_e r);
        case (r)
            RATE_2_3: return 7'b0000011;
            RATE_3_4: return 7'b0000011;
            RATE_5_6: return 7'b0001011;
            RATE_6_7: return 7'b0010111;
            RATE_7_8: return 7'b0101111;
            default:  return 7'b0000001;
        endcase
    endfunction

    function automatic col_t period_len(input rate_e r);
        case (r)
            RATE_2_3: return 3'd2;
            RATE_3_4: return 3'd3;
            RATE_5_6: return 3'd5;
            RATE_6_7: return 3'd6;
            RATE_7_8: return 3'd7;
            default:  return 3'd1;
        endcase
    endfunction

    // phase modulo len by repeated subtraction (len >= 1, phase <= 7)
    function automatic col_t wrap_phase(input logic [2:0] ph, input col_t len);
        col_t v;
        v = ph;
        for (int k = 0; k < MAX_COLS; k++) begin
            if (v >= len) v = v - len;
        end
        return v;
    endfunction

endpackage

// File: rtl/depunct_cfg.sv
module depunct_cfg
    import depunct_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic [2:0] rate_code,
    input  logic [2:0] phase,
    output pat_cfg_t cfg,
    output logic     flush
);

    logic [5:0] key_q;
    logic [5:0] key_now;
    rate_e      rate;

    assign key_now = {rate_code, phase};
    assign rate    = decode_rate(rate_code);

    always_comb begin
        cfg.len   = period_len(rate);
        cfg.start = wrap_phase(phase, cfg.len);
        cfg.xm    = x_mask(rate);
        cfg.ym    = y_mask(rate);
    end

    always_ff @(posedge clk) begin
        key_q <= key_now;
    end

    assign flush = !rst && (key_now != key_q);

    AST_START_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
        cfg.start < cfg.len); // R5

endmodule

// File: rtl/depunct_fifo.sv
module depunct_fifo #(
    parameter int W     = 3,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     din0,
    input  logic [W-1:0]     din1,
    input  logic [1:0]       pop_n,
    output logic [W-1:0]     head0,
    output logic [W-1:0]     head1,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] nxt [DEPTH];
    logic [CNT_W-1:0] count_nxt;

    // Shift out pop_n entries from the front and append the pushed pair behind the survivors
    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            int src;
            src = j + int'(pop_n);
            nxt[j] = '0;
            if (src < int'(count))
                nxt[j] = mem[src[IDX_W-1:0]];
            else if (push && src == int'(count))
                nxt[j] = din0;
            else if (push && src == int'(count) + 1)
                nxt[j] = din1;
        end
        count_nxt = count - CNT_W'(pop_n) + (push ? CNT_W'(2) : CNT_W'(0));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            count <= '0;
            for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
        end else begin
            count <= count_nxt;
            for (int j = 0; j < DEPTH; j++) mem[j] <= nxt[j];
        end
    end

    assign head0 = mem[0];
    assign head1 = mem[(DEPTH > 1) ? 1 : 0];

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        !flush |-> int'(pop_n) <= int'(count)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && !flush) |-> (int'(count) - int'(pop_n) + 2 <= DEPTH)); // R10

endmodule

// File: rtl/depunct_sel.sv
module depunct_sel
    import depunct_pkg::*;
#(
    parameter int W     = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  pat_cfg_t         cfg,
    input  logic [CNT_W-1:0] count,
    input  logic [W-1:0]     head0,
    input  logic [W-1:0]     head1,
    output logic [1:0]       pop_n,
    output logic             out_valid,
    output logic [W-1:0]     out_x,
    output logic [W-1:0]     out_y,
    output logic             out_x_era,
    output logic             out_y_era,
    output logic             period_start
);

    col_t       col;
    logic       x_keep;
    logic       y_keep;
    logic [1:0] need;
    logic       fire;

    assign x_keep = cfg.xm[col];
    assign y_keep = cfg.ym[col];
    assign need   = {1'b0, x_keep} + {1'b0, y_keep};
    assign fire   = !flush && (CNT_W'(need) <= count) && (need != 2'd0);
    assign pop_n  = fire ? need : 2'd0;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            col <= cfg.start;
        end else if (fire) begin
            col <= (col == cfg.len - 3'd1) ? 3'd0 : col + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !fire) begin
            out_valid    <= 1'b0;
            out_x        <= '0;
            out_y        <= '0;
            out_x_era    <= 1'b0;
            out_y_era    <= 1'b0;
            period_start <= 1'b0;
        end else begin
            out_valid    <= 1'b1;
            out_x        <= x_keep ? head0 : '0;
            out_y        <= y_keep ? (x_keep ? head1 : head0) : '0;
            out_x_era    <= !x_keep;
            out_y_era    <= !y_keep;
            period_start <= (col == 3'd0);
        end
    end

    AST_COL_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        !flush |-> col < cfg.len); // R5
    AST_FLUSH_SILENCE: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid); // R7

endmodule

// File: rtl/depuncturer.sv
module depuncturer
    import depunct_pkg::*;
#(
    parameter int SOFT_W = 3,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        rate_code,
    input  logic [2:0]        phase,
    input  logic              in_valid,
    input  logic [SOFT_W-1:0] in_i,
    input  logic [SOFT_W-1:0] in_q,
    output logic              out_valid,
    output logic [SOFT_W-1:0] out_x,
    output logic [SOFT_W-1:0] out_y,
    output logic              out_x_era,
    output logic              out_y_era,
    output logic              period_start
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    pat_cfg_t          cfg;
    logic              flush;
    logic [1:0]        pop_n;
    logic [SOFT_W-1:0] head0;
    logic [SOFT_W-1:0] head1;
    logic [CNT_W-1:0]  count;

    depunct_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .rate_code (rate_code),
        .phase     (phase),
        .cfg       (cfg),
        .flush     (flush)
    );

    depunct_fifo #(.W(SOFT_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (in_valid),
        .din0  (in_i),
        .din1  (in_q),
        .pop_n (pop_n),
        .head0 (head0),
        .head1 (head1),
        .count (count)
    );

    depunct_sel #(.W(SOFT_W), .CNT_W(CNT_W)) u_sel (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .cfg          (cfg),
        .count        (count),
        .head0        (head0),
        .head1        (head1),
        .pop_n        (pop_n),
        .out_valid    (out_valid),
        .out_x        (out_x),
        .out_y        (out_y),
        .out_x_era    (out_x_era),
        .out_y_era    (out_y_era),
        .period_start (period_start)
    );

    AST_ERASED_X_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_x_era) |-> out_x == '0); // R4
    AST_ERASED_Y_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_y_era) |-> out_y == '0); // R4
    AST_ONE_TERM_KEPT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_x_era && out_y_era)); // R4
    AST_PERIOD_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        period_start |-> out_valid); // R6

endmodule

// File: tb/depuncturer_tb.sv
module depuncturer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [2:0] rate;
        logic [2:0] ph;
        logic [7:0] nstr;
        logic [7:0] pairs;
    } vec_t;

    // rate, phase, strobes, expected pairs (worked out from R2 and R5)
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 3'd0, 8'd4, 8'd4},
        '{3'd1, 3'd0, 8'd3, 8'd4},
        '{3'd1, 3'd1, 8'd3, 8'd4},
        '{3'd2, 3'd0, 8'd4, 8'd6},
        '{3'd3, 3'd2, 8'd6, 8'd10},
        '{3'd4, 3'd5, 8'd7, 8'd12},
        '{3'd5, 3'd3, 8'd8, 8'd14},
        '{3'd6, 3'd0, 8'd2, 8'd2},
        '{3'd1, 3'd0, 8'd1, 8'd1},
        '{3'd1, 3'd3, 8'd2, 8'd3}
    };

    // Bench copy of the R2 pattern table, bit c = column c
    localparam logic [6:0] TB_XM [6] = '{7'b0000001, 7'b0000001, 7'b0000101,
                                         7'b0010101, 7'b0101001, 7'b1010001};
    localparam logic [6:0] TB_YM [6] = '{7'b0000001, 7'b0000011, 7'b0000011,
                                         7'b0001011, 7'b0010111, 7'b0101111};
    localparam int TB_LEN [6] = '{1, 2, 3, 5, 6, 7};

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] rate_code;
    logic [2:0] phase;
    logic       in_valid;
    logic [2:0] in_i;
    logic [2:0] in_q;
    logic       out_valid;
    logic [2:0] out_x;
    logic [2:0] out_y;
    logic       out_x_era;
    logic       out_y_era;
    logic       period_start;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [2:0] sym_log [512];
    int         sym_n;
    int         sym_total = 0;
    logic [8:0] mon_log [512];
    int         mon_total = 0;
    int         mon_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    depuncturer dut_i (
        .clk          (clk),
        .rst          (rst),
        .rate_code    (rate_code),
        .phase        (phase),
        .in_valid     (in_valid),
        .in_i         (in_i),
        .in_q         (in_q),
        .out_valid    (out_valid),
        .out_x        (out_x),
        .out_y        (out_y),
        .out_x_era    (out_x_era),
        .out_y_era    (out_y_era),
        .period_start (period_start)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && mon_total < 512) begin
            mon_log[mon_total] = {out_x, out_y, out_x_era, out_y_era, period_start};
            mon_total = mon_total + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] r, input logic [2:0] p, input bit junk);
        @(negedge clk);
        rate_code = r;
        phase = p;
        in_valid = junk;
        in_i = 3'b111;
        in_q = 3'b111;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic feed(input int n);
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            in_i = 3'((sym_total * 3 + 5) % 8);
            in_q = 3'(((sym_total + 1) * 3 + 5) % 8);
            sym_log[sym_n] = in_i;
            sym_log[sym_n + 1] = in_q;
            sym_n += 2;
            sym_total += 2;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic begin_case();
        mon_base = mon_total;
        sym_n = 0;
    endtask

    // Independent model: walk the pattern over the logged symbols and compare each pair
    task automatic check_stream(input logic [2:0] rate, input logic [2:0] ph,
                                input int exp_pairs, input string tag);
        int r;
        int col;
        int idx;
        int n;
        repeat (20) @(negedge clk);
        r = (rate > 3'd5) ? 0 : int'(rate);
        col = int'(ph) % TB_LEN[r];
        n = mon_total - mon_base;
        check(n == exp_pairs, {tag, " pair count"}, n, exp_pairs);
        idx = 0;
        for (int p = 0; p < n && p < exp_pairs; p++) begin
            logic [2:0] ex;
            logic [2:0] ey;
            logic       xk;
            logic       yk;
            logic [8:0] expw;
            xk = TB_XM[r][col];
            yk = TB_YM[r][col];
            ex = 3'b000;
            ey = 3'b000;
            if (xk) begin ex = sym_log[idx]; idx++; end
            if (yk) begin ey = sym_log[idx]; idx++; end
            expw = {ex, ey, !xk, !yk, (col == 0)};
            check(mon_log[mon_base + p] == expw, {tag, " pair content"},
                  int'(mon_log[mon_base + p]), int'(expw));
            col = (col + 1) % TB_LEN[r];
        end
    endtask

    initial begin
        rst = 1'b1;
        rate_code = 3'd0;
        phase = 3'd0;
        in_valid = 1'b0;
        in_i = 3'd0;
        in_q = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !period_start, "R8 outputs in reset",
              int'({out_valid, period_start}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !period_start, "R8 outputs after reset",
              int'({out_valid, period_start}), 0);

        // Table walk: R1 R2 R3 R4 R5 R6 R9 R10 across rates and phases
        for (int v = 0; v < NVEC; v++) begin
            begin_case();
            set_cfg(VECS[v].rate, VECS[v].ph, 1'b0);
            feed(int'(VECS[v].nstr));
            check_stream(VECS[v].rate, VECS[v].ph, int'(VECS[v].pairs),
                         (VECS[v].rate > 3'd5) ? "R1 invalid code as 1/2"
                                               : "R2 R3 R4 R5 R6 R10 table");
        end

        // R9: rate 2/3 phase 1, one strobe -> column 1 pair, one symbol held
        begin_case();
        set_cfg(3'd1, 3'd1, 1'b0);
        feed(1);
        check_stream(3'd1, 3'd1, 1, "R9 partial column held");

        // R7: phase change with a strobe in the same cycle; held symbol and strobe dropped
        begin_case();
        set_cfg(3'd1, 3'd0, 1'b1);
        feed(2);
        check_stream(3'd1, 3'd0, 2, "R7 flush on change");

        // R8: leave one symbol buffered, reset with the same settings, then feed fresh data
        begin_case();
        set_cfg(3'd1, 3'd1, 1'b0);
        feed(1);
        check_stream(3'd1, 3'd1, 1, "R9 leftover before reset");
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && !period_start, "R8 outputs in second reset",
              int'({out_valid, period_start}), 0);
        rst = 1'b0;
        begin_case();
        feed(2);
        check_stream(3'd1, 3'd1, 3, "R8 buffer cleared by reset");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule